// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of several DMA channels may use a single shared bus for its next item transfer. Each channel raises a request when it is enabled and any one of its peripheral request lines is high, or, in memory-to-memory mode, whenever it is enabled. Each channel also carries a two-bit software priority level.

The arbiter runs in two tiers. The highest software level among the requesting channels wins. Among channels at that level, the lowest channel number wins. The winner is registered and held for the whole item. The arbiter chooses again only when the bus side reports the end of the item, or when no grant is outstanding. The outputs are a one-hot grant, the binary index of the granted channel and a valid flag. Data movement, registers and bus timing belong to the neighbouring blocks.

Top module: `dma_prio_arbiter`

## Requirements
- R1: A channel requests only while its `ch_enable` bit is 1 and at least one of its `REQ_LINES` request lines is high (lines of channel c occupy `periph_req[c*REQ_LINES +: REQ_LINES]`). A disabled channel is never granted, whatever its lines do.
- R2: A channel whose `ch_m2m` bit is 1 requests continuously while it is enabled, even with all of its lines low.
- R3: The software level is `ch_prio[2*c +: 2]`: 0 is low, 1 medium, 2 high and 3 very high. A requesting channel at a higher level always beats one at a lower level, whatever their channel numbers.
- R4: Among requesting channels at the same level, the lowest channel number is granted.
- R5: While a grant is outstanding and `item_done` is 0, the grant does not change, even if the granted channel drops its request or a higher-level channel starts requesting.
- R6: A cycle with a grant outstanding and `item_done` = 1 re-runs arbitration on that cycle's inputs. The result appears on the outputs from the next cycle on, and it may be the same channel.
- R7: With no grant outstanding, arbitration runs every cycle. A request seen at a clock edge produces its grant in the cycle that follows.
- R8: When arbitration finds no request, `grant` is all zero, `grant_idx` is 0 and `grant_valid` is 0.
- R9: `grant` is one-hot or zero. When it is non-zero, `grant_valid` is 1 and `grant_idx` is the number of the set bit.
- R10: During reset and right after it, no grant is outstanding.
- R11: `item_done` has no effect while no grant is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_m2m | input | NUM_CH | Per-channel memory-to-memory mode |
| ch_prio | input | 2*NUM_CH | Per-channel software level, two bits each |
| periph_req | input | NUM_CH*REQ_LINES | Peripheral request lines, grouped by channel |
| item_done | input | 1 | End of the item currently granted |
| grant | output | NUM_CH | One-hot grant |
| grant_idx | output | IDX_W | Index of the granted channel |
| grant_valid | output | 1 | A grant is outstanding |

## Verification
The hardest case to reach is a higher-level channel that starts requesting while a lower-level item is still in flight. The stimulus first lets a low-level channel win. It then holds `item_done` low for several cycles while a very-high-level channel raises its request, and the old grant must stay put. Only after that does it pulse `item_done`, so that the winner changes on the boundary. A long random phase then mixes enables, levels, memory-to-memory bits and sparse line activity with random item completions, and the outputs are compared with a reference model on every cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   localparam int PRIO_W = 2;

   typedef enum logic [PRIO_W-1:0] {
      LVL_LOW   = 2'd0,
      LVL_MED   = 2'd1,
      LVL_HIGH  = 2'd2,
      LVL_VHIGH = 2'd3
   } prio_lvl_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dma_arb_req.sv
// Forms each channel's effective request from its lines, enable and mode.
module dma_arb_req #(
   parameter int NUM_CH    = 7,
   parameter int REQ_LINES = 6
) (
   input  logic [NUM_CH*REQ_LINES-1:0] line_i,
   input  logic [NUM_CH-1:0]           en_i,
   input  logic [NUM_CH-1:0]           m2m_i,
   output logic [NUM_CH-1:0]           req_o
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic any_line;
      assign any_line   = |line_i[ch*REQ_LINES +: REQ_LINES];
      assign req_o[ch]  = en_i[ch] & (m2m_i[ch] | any_line);
   end
endmodule

// File: rtl/dma_arb_pick.sv
// Two-tier winner selection: level first, lower channel number on ties.
module dma_arb_pick
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 7,
   localparam int IDX_W = idx_width(NUM_CH)
) (
   input  logic [NUM_CH-1:0]        req_i,
   input  logic [NUM_CH*PRIO_W-1:0] prio_i,
   output logic [NUM_CH-1:0]        win_oh_o,
   output logic [IDX_W-1:0]         win_idx_o,
   output logic                     win_vld_o
);
   logic [PRIO_W-1:0] best_lvl;
   logic [IDX_W-1:0]  best_idx;
   logic              best_vld;

   always_comb begin
      best_lvl = '0;
      best_idx = '0;
      best_vld = 1'b0;
      // Ascending scan with strict compare keeps the lowest index on a tie.
      for (int c = 0; c < NUM_CH; c++) begin
         if (req_i[c] && (!best_vld || (prio_i[c*PRIO_W +: PRIO_W] > best_lvl))) begin
            best_lvl = prio_i[c*PRIO_W +: PRIO_W];
            best_idx = IDX_W'(c);
            best_vld = 1'b1;
         end
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_oh
      assign win_oh_o[c] = best_vld && (best_idx == IDX_W'(c));
   end

   assign win_idx_o = best_idx;
   assign win_vld_o = best_vld;
endmodule

// File: rtl/dma_arb_hold.sv
// Grant register: reloads only when idle or at an item boundary.
module dma_arb_hold #(
   parameter int NUM_CH = 7,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [NUM_CH-1:0] win_oh_i,
   input  logic [IDX_W-1:0]  win_idx_i,
   output logic [NUM_CH-1:0] grant_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              busy_o
);
   logic [NUM_CH-1:0] grant_q;
   logic [IDX_W-1:0]  idx_q;
   logic              open_win;

   assign busy_o   = |grant_q;
   assign open_win = !busy_o || done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= '0;
         idx_q   <= '0;
      end else if (open_win) begin
         grant_q <= win_oh_i;
         idx_q   <= win_idx_i;
      end
   end

   assign grant_o = grant_q;
   assign idx_o   = idx_q;
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH    = 7,
   parameter int REQ_LINES = 6,
   localparam int IDX_W    = idx_width(NUM_CH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CH-1:0]           ch_enable,
   input  logic [NUM_CH-1:0]           ch_m2m,
   input  logic [NUM_CH*PRIO_W-1:0]    ch_prio,
   input  logic [NUM_CH*REQ_LINES-1:0] periph_req,
   input  logic                        item_done,
   output logic [NUM_CH-1:0]           grant,
   output logic [IDX_W-1:0]            grant_idx,
   output logic                        grant_valid
);
   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("dma_prio_arbiter: NUM_CH must lie in 1..16");
   end
   if (REQ_LINES < 3 || REQ_LINES > 6) begin : g_bad_lines
      $error("dma_prio_arbiter: REQ_LINES must lie in 3..6");
   end

   logic [NUM_CH-1:0] ch_req;
   logic [NUM_CH-1:0] win_oh;
   logic [IDX_W-1:0]  win_idx;
   logic              win_vld;

   dma_arb_req #(.NUM_CH(NUM_CH), .REQ_LINES(REQ_LINES)) u_req (
      .line_i (periph_req),
      .en_i   (ch_enable),
      .m2m_i  (ch_m2m),
      .req_o  (ch_req)
   );

   dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
      .req_i     (ch_req),
      .prio_i    (ch_prio),
      .win_oh_o  (win_oh),
      .win_idx_o (win_idx),
      .win_vld_o (win_vld)
   );

   dma_arb_hold #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (item_done),
      .win_oh_i  (win_oh),
      .win_idx_i (win_idx),
      .grant_o   (grant),
      .idx_o     (grant_idx),
      .busy_o    (grant_valid)
   );

   logic unused_vld;
   assign unused_vld = win_vld;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH    = 7,
   parameter int REQ_LINES = 6,
   localparam int IDX_W    = idx_width(NUM_CH)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_CH-1:0]           ch_enable,
   input logic [NUM_CH-1:0]           ch_m2m,
   input logic [NUM_CH*REQ_LINES-1:0] periph_req,
   input logic                        item_done,
   input logic [NUM_CH-1:0]           grant,
   input logic [IDX_W-1:0]            grant_idx,
   input logic                        grant_valid
);
   logic any_req;
   always_comb begin
      any_req = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ch_enable[c] && (ch_m2m[c] || (|periph_req[c*REQ_LINES +: REQ_LINES])))
            any_req = 1'b1;
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R9

   AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> ((grant >> grant_idx) == 1)); // R9

   AST_HOLD_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !item_done) |=> ($stable(grant) && $stable(grant_idx))); // R5

   AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_valid || item_done) |=> ((grant & ~$past(ch_enable)) == '0)); // R1

   AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_valid && !any_req) |=> (!grant_valid && grant_idx == '0)); // R8
endmodule

bind dma_prio_arbiter dma_arb_checker #(.NUM_CH(NUM_CH), .REQ_LINES(REQ_LINES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ch_enable   (ch_enable),
   .ch_m2m      (ch_m2m),
   .periph_req  (periph_req),
   .item_done   (item_done),
   .grant       (grant),
   .grant_idx   (grant_idx),
   .grant_valid (grant_valid)
);

// File: tb/dma_prio_arbiter_bench.sv
module dma_prio_arbiter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 7;
   localparam int NL   = 6;
   localparam int IW   = 3;
   localparam int WDOG = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH-1:0]    en = '0;
   logic [NCH-1:0]    m2m = '0;
   logic [NCH*2-1:0]  prio = '0;
   logic [NCH*NL-1:0] lines = '0;
   logic              done = 1'b0;
   logic [NCH-1:0]    grant;
   logic [IW-1:0]     grant_idx;
   logic              grant_valid;

   int checks = 0;
   int errors = 0;
   int exp_ch = -1;
   int cycles = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_prio_arbiter #(.NUM_CH(NCH), .REQ_LINES(NL)) u_dma_prio_arbiter (
      .clk(clk), .rst_n(rst_n), .ch_enable(en), .ch_m2m(m2m), .ch_prio(prio),
      .periph_req(lines), .item_done(done), .grant(grant),
      .grant_idx(grant_idx), .grant_valid(grant_valid)
   );

   // Behavioural reference: which channel holds the bus.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) exp_ch = -1;
      else if (exp_ch < 0 || done) begin
         int best;
         best = -1;
         for (int c = 0; c < NCH; c++) begin
            bit wants;
            wants = en[c] && (m2m[c] || (lines[c*NL +: NL] != 0));
            if (wants && (best < 0 || prio[2*c +: 2] > prio[2*best +: 2])) best = c;
         end
         exp_ch = best;
      end
   end

   task automatic check_now(input string tag);
      logic [NCH-1:0] eg;
      logic [IW-1:0]  ei;
      eg = (exp_ch < 0) ? '0 : (NCH'(1) << exp_ch);
      ei = (exp_ch < 0) ? '0 : IW'(exp_ch);
      checks++;
      if (grant !== eg || grant_idx !== ei || grant_valid !== (exp_ch >= 0)) begin
         errors++;
         $display("FAIL %s: grant=%b idx=%0d valid=%b expected grant=%b idx=%0d valid=%b",
                  tag, grant, grant_idx, grant_valid, eg, ei, exp_ch >= 0);
      end
   endtask

   task automatic cyc(input string tag, input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_now(tag);
      end
   endtask

   task automatic set_lvl(input int c, input int lvl);
      prio[2*c +: 2] = 2'(lvl);
   endtask

   task automatic pulse_done(input string tag);
      done = 1'b1;
      cyc(tag);
      done = 1'b0;
   endtask

   task automatic clear_all();
      en = '0; m2m = '0; lines = '0; prio = '0;
      pulse_done("R6");
      cyc("R8", 2);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG && !finished) begin
         errors++;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      cyc("R10", 2);
      rst_n = 1'b1;
      cyc("R10");
      cyc("R8", 3);
      // R11: item_done while idle
      done = 1'b1; cyc("R11", 3); done = 1'b0; cyc("R11");

      // R1: lines high on a disabled channel
      lines[2*NL + 1] = 1'b1;
      cyc("R1", 3);
      en[2] = 1'b1;                 // R7: grant one cycle later
      cyc("R7");
      cyc("R1", 2);
      lines[2*NL + 1] = 1'b0;
      pulse_done("R1");
      lines[3*NL + NL-1] = 1'b1; en[3] = 1'b1;   // highest line of channel 3
      cyc("R1", 2);
      clear_all();

      // R2: memory-to-memory without lines
      m2m[5] = 1'b1; cyc("R2", 2);  // not enabled yet
      en[5] = 1'b1; cyc("R2", 2);
      pulse_done("R2"); cyc("R2");  // still requesting, same winner
      clear_all();

      // R3: higher level beats lower number
      en = '1; lines[0] = 1'b1; lines[6*NL] = 1'b1;
      set_lvl(0, 0); set_lvl(6, 3);
      cyc("R3", 2);
      set_lvl(0, 2); set_lvl(6, 1); pulse_done("R3"); cyc("R3");
      clear_all();

      // R4: equal level, lower number wins
      en = '1; set_lvl(1, 2); set_lvl(4, 2);
      lines[4*NL + 2] = 1'b1; lines[1*NL + 0] = 1'b1;
      cyc("R4", 2);
      lines[1*NL + 0] = 1'b0; pulse_done("R4"); cyc("R4");
      clear_all();

      // R5/R6: no pre-emption; change only at the boundary
      en = '1; set_lvl(3, 0); lines[3*NL] = 1'b1;
      cyc("R5");
      set_lvl(6, 3); lines[6*NL + 3] = 1'b1;
      cyc("R5", 4);
      lines[3*NL] = 1'b0; cyc("R5", 2);     // dropped request keeps the grant
      en[3] = 1'b0; cyc("R5", 2);           // disabled mid-item keeps the grant
      pulse_done("R6"); cyc("R6", 2);
      done = 1'b1; cyc("R6", 3); done = 1'b0;  // back-to-back items
      clear_all();

      // R9: random mix
      for (int k = 0; k < 600; k++) begin
         en    = NCH'($urandom);
         m2m   = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
         prio  = (NCH*2)'($urandom);
         lines = '0;
         for (int c = 0; c < NCH; c++)
            if ($urandom_range(0, 2) == 0) lines[c*NL + $urandom_range(0, NL-1)] = 1'b1;
         done = ($urandom_range(0, 9) < 3);
         cyc("R9");
      end
      done = 1'b0;
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule